// File: doc/BRIEF.md
# Shadowed Control Register Bank with Write Lock

This block holds the configuration bytes of a temperature-compensated current generator in a sixteen-byte window starting at 80h. Two of the bytes (the direct lookup-row index at 81h and the direct DAC code at 83h) exist twice. One copy is a working copy that drives the datapath. The other is a retained copy that stands for the nonvolatile cell. Both copies are ordinary flops. The remaining control bytes hold single retained values. The block also holds a global write-enable latch and carries a status byte through for reading.

A host writes through a one-cycle byte strobe and reads combinationally by address. Writes are qualified by two things: the write-enable latch, which only exact byte values can set or clear, and an active-low write-protect input. A volatility bit in 80h decides whether writes to the paired bytes also reach their retained copies. Certain writes copy retained values back into the working copies. The decoded fields leave the block as discrete outputs.

Top module: `cfg_shadow_regfile`

## Requirements
- R1: The latch is read back as bit 7 of 86h, and the other bits of 86h read 0. Writing exactly 80h to 86h sets the latch and writing exactly 00h clears it. Any other byte written to 86h leaves it unchanged.
- R2: While the latch is 0, writes to every address other than 86h have no effect.
- R3: While `wp_n` is 0, writes to every address other than 86h have no effect. A write to 86h still acts on the latch.
- R4: After reset the latch is 0, 80h reads 08h, 85h reads 03h, 81h/83h/86h read 00h, and `fs_sel` is 3. Both copies of 81h and 83h are 00h.
- R5: With the volatility bit at 0, an accepted write to 81h (bits 5..0) or to 83h (8 bits) changes only the working copy. The readback of that address is unchanged.
- R6: With the volatility bit at 1, an accepted write to 81h or 83h updates both copies.
- R7: An accepted write to 81h loads the working copy of 83h from its retained copy. An accepted write to 83h loads the working copy of 81h from its retained copy.
- R8: An accepted write to 80h or 85h, while the volatility bit (its value before the write) is 0, loads both working copies from their retained copies.
- R9: Reads of 81h and 83h return the retained copy, with bits 7..6 of 81h reading 0. A read of 87h returns `status_in`.
- R10: Field layout. In 80h, bit 5 is `cur_dir`, bit 4 is `vol_mode`, bit 2 is `filt_off`, and bit 3 always reads 1. In 85h, bit 5 is `dac_direct`, bit 4 is `lut_direct`, and bits 1..0 are `fs_sel`. All other bits of these two bytes read 0.
- R11: Addresses 82h, 84h and 88h..8Fh, and any address outside 80h..8Fh, ignore writes and read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wp_n | input | 1 | Write protect, active low |
| status_in | input | 8 | Conversion status byte shown at 87h |
| wel | output | 1 | Write-enable latch |
| cur_dir | output | 1 | Current direction (1 = sink) |
| vol_mode | output | 1 | Volatility bit for 81h/83h |
| filt_off | output | 1 | Conversion filter disable |
| dac_direct | output | 1 | DAC driven from 83h |
| lut_direct | output | 1 | Lookup row taken from 81h |
| fs_sel | output | 2 | Full-scale current select |
| lut_row | output | 6 | Working copy of 81h |
| dac_code | output | 8 | Working copy of 83h |

## Verification
The hardest state to reach from the ports is a divergence between the working and retained copies of a paired byte. Only that divergence makes a recall or a retained-copy readback visible. The stimulus first clears the volatility bit and writes one paired byte. It then checks that the readback still shows the old retained value while the output shows the new one. Next it issues the write that should recall, and checks the output snapping back. The write-enable latch is swept over all 256 data values against a running model, so that only the two exact bytes move it.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
    localparam int DW = 8;
    localparam int OFF_W = 4;

    localparam logic [OFF_W-1:0] OFF_CTL0 = 4'h0;
    localparam logic [OFF_W-1:0] OFF_ROW  = 4'h1;
    localparam logic [OFF_W-1:0] OFF_CODE = 4'h3;
    localparam logic [OFF_W-1:0] OFF_CTL5 = 4'h5;
    localparam logic [OFF_W-1:0] OFF_WEL  = 4'h6;
    localparam logic [OFF_W-1:0] OFF_STAT = 4'h7;

    localparam logic [DW-1:0] WEL_SET_BYTE = 8'h80;
    localparam logic [DW-1:0] WEL_CLR_BYTE = 8'h00;

    typedef struct packed {
        logic dir;
        logic vol;
        logic filt;
    } ctl0_t;

    typedef struct packed {
        logic       dac_dir;
        logic       lut_dir;
        logic [1:0] fs;
    } ctl5_t;

    typedef struct packed {
        logic wr_ctl0;
        logic wr_row;
        logic wr_code;
        logic wr_ctl5;
    } wr_hit_t;

    function automatic ctl0_t ctl0_from_byte(input logic [DW-1:0] b);
        ctl0_t c;
        c.dir  = b[5];
        c.vol  = b[4];
        c.filt = b[2];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctl0_to_byte(input ctl0_t c);
        return {2'b00, c.dir, c.vol, 1'b1, c.filt, 2'b00};
    endfunction

    function automatic ctl5_t ctl5_from_byte(input logic [DW-1:0] b);
        ctl5_t c;
        c.dac_dir = b[5];
        c.lut_dir = b[4];
        c.fs      = b[1:0];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctl5_to_byte(input ctl5_t c);
        return {2'b00, c.dac_dir, c.lut_dir, 2'b00, c.fs};
    endfunction
endpackage

// File: rtl/cfg_wr_gate.sv
module cfg_wr_gate
    import cfg_shadow_pkg::*;
#(
    parameter logic [DW-1:0] BASE_ADDR = 8'h80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [DW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             wp_n,
    output logic             wel,
    output wr_hit_t          hit
);
    localparam int HI_W = DW - OFF_W;

    logic             in_win;
    logic [OFF_W-1:0] off;
    logic             ok;

    assign in_win = (wr_addr[DW-1:OFF_W] == BASE_ADDR[DW-1:OFF_W]);
    assign off    = wr_addr[OFF_W-1:0];
    assign ok     = wr_stb && in_win && wel && wp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
        end else if (wr_stb && in_win && off == OFF_WEL) begin
            if (wr_data == WEL_SET_BYTE)
                wel <= 1'b1;
            else if (wr_data == WEL_CLR_BYTE)
                wel <= 1'b0;
        end
    end

    always_comb begin
        hit         = '0;
        hit.wr_ctl0 = ok && (off == OFF_CTL0);
        hit.wr_row  = ok && (off == OFF_ROW);
        hit.wr_code = ok && (off == OFF_CODE);
        hit.wr_ctl5 = ok && (off == OFF_CTL5);
    end

    logic unused_hi;
    assign unused_hi = ^BASE_ADDR[HI_W-1:0] & 1'b0;
endmodule

// File: rtl/cfg_shadow_pair.sv
module cfg_shadow_pair #(
    parameter int          W     = 8,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_work,
    input  logic         wr_keep,
    input  logic         recall,
    input  logic [W-1:0] din,
    output logic [W-1:0] work_q,
    output logic [W-1:0] keep_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= RST_V;
        end else if (wr_keep) begin
            keep_q <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= RST_V;
        end else if (wr_work) begin
            work_q <= din;
        end else if (recall) begin
            work_q <= keep_q;
        end
    end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
    import cfg_shadow_pkg::*;
#(
    parameter logic [DW-1:0] BASE_ADDR = 8'h80,
    parameter int            ROW_W     = 6
) (
    input  logic [DW-1:0]    rd_addr,
    input  ctl0_t            c0,
    input  ctl5_t            c5,
    input  logic [ROW_W-1:0] keep_row,
    input  logic [DW-1:0]    keep_code,
    input  logic             wel,
    input  logic [DW-1:0]    status_in,
    output logic [DW-1:0]    rd_data
);
    logic in_win;
    assign in_win = (rd_addr[DW-1:OFF_W] == BASE_ADDR[DW-1:OFF_W]);

    always_comb begin
        rd_data = '0;
        if (in_win) begin
            case (rd_addr[OFF_W-1:0])
                OFF_CTL0: rd_data = ctl0_to_byte(c0);
                OFF_ROW:  rd_data = {{(DW-ROW_W){1'b0}}, keep_row};
                OFF_CODE: rd_data = keep_code;
                OFF_CTL5: rd_data = ctl5_to_byte(c5);
                OFF_WEL:  rd_data = {wel, {(DW-1){1'b0}}};
                OFF_STAT: rd_data = status_in;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_shadow_regfile.sv
module cfg_shadow_regfile
    import cfg_shadow_pkg::*;
#(
    parameter logic [DW-1:0] BASE_ADDR = 8'h80,
    parameter int            ROW_W     = 6,
    parameter logic [1:0]    FS_RESET  = 2'b11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [DW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             wp_n,
    input  logic [DW-1:0]    status_in,
    output logic             wel,
    output logic             cur_dir,
    output logic             vol_mode,
    output logic             filt_off,
    output logic             dac_direct,
    output logic             lut_direct,
    output logic [1:0]       fs_sel,
    output logic [ROW_W-1:0] lut_row,
    output logic [DW-1:0]    dac_code
);
    wr_hit_t          hit;
    ctl0_t            c0;
    ctl5_t            c5;
    logic             recall_all;
    logic [ROW_W-1:0] nv_row;
    logic [DW-1:0]    nv_code;

    cfg_wr_gate #(.BASE_ADDR(BASE_ADDR)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wp_n    (wp_n),
        .wel     (wel),
        .hit     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            c0 <= '0;
            c5 <= '{dac_dir: 1'b0, lut_dir: 1'b0, fs: FS_RESET};
        end else begin
            if (hit.wr_ctl0) c0 <= ctl0_from_byte(wr_data);
            if (hit.wr_ctl5) c5 <= ctl5_from_byte(wr_data);
        end
    end

    assign recall_all = (hit.wr_ctl0 || hit.wr_ctl5) && !c0.vol;

    cfg_shadow_pair #(.W(ROW_W), .RST_V('0)) u_row (
        .clk     (clk),
        .rst     (rst),
        .wr_work (hit.wr_row),
        .wr_keep (hit.wr_row && c0.vol),
        .recall  (recall_all || hit.wr_code),
        .din     (wr_data[ROW_W-1:0]),
        .work_q  (lut_row),
        .keep_q  (nv_row)
    );

    cfg_shadow_pair #(.W(DW), .RST_V('0)) u_code (
        .clk     (clk),
        .rst     (rst),
        .wr_work (hit.wr_code),
        .wr_keep (hit.wr_code && c0.vol),
        .recall  (recall_all || hit.wr_row),
        .din     (wr_data),
        .work_q  (dac_code),
        .keep_q  (nv_code)
    );

    cfg_rd_mux #(.BASE_ADDR(BASE_ADDR), .ROW_W(ROW_W)) u_rd (
        .rd_addr   (rd_addr),
        .c0        (c0),
        .c5        (c5),
        .keep_row  (nv_row),
        .keep_code (nv_code),
        .wel       (wel),
        .status_in (status_in),
        .rd_data   (rd_data)
    );

    assign cur_dir    = c0.dir;
    assign vol_mode   = c0.vol;
    assign filt_off   = c0.filt;
    assign dac_direct = c5.dac_dir;
    assign lut_direct = c5.lut_dir;
    assign fs_sel     = c5.fs;
endmodule

// File: rtl/cfg_shadow_chk.sv
module cfg_shadow_chk #(
    parameter logic [7:0] BASE_ADDR = 8'h80,
    parameter int          ROW_W    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_stb,
    input logic [7:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             wp_n,
    input logic             wel,
    input logic             vol_mode,
    input logic [ROW_W-1:0] lut_row,
    input logic [7:0]       dac_code,
    input logic [ROW_W-1:0] nv_row,
    input logic [7:0]       nv_code,
    input logic [5:0]       ctl_bits
);
    logic [7:0] a_wel, a_c0, a_row, a_code, a_c5;
    logic       acc;
    assign a_wel  = BASE_ADDR + 8'h6;
    assign a_c0   = BASE_ADDR;
    assign a_row  = BASE_ADDR + 8'h1;
    assign a_code = BASE_ADDR + 8'h3;
    assign a_c5   = BASE_ADDR + 8'h5;
    assign acc    = wr_stb && wel && wp_n;

    assert_wel_set_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(wr_stb && wr_addr == a_wel && wr_data == 8'h80));

    assert_wel_clr_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(wel) |-> $past(wr_stb && wr_addr == a_wel && wr_data == 8'h00));

    assert_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wel && wr_addr != a_wel) |=>
        ($stable(lut_row) && $stable(dac_code) && $stable(nv_row) &&
         $stable(nv_code) && $stable(ctl_bits)));

    assert_protect_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wp_n && wr_addr != a_wel) |=>
        ($stable(lut_row) && $stable(dac_code) && $stable(nv_row) &&
         $stable(nv_code) && $stable(ctl_bits)));

    assert_work_only_R5: assert property (@(posedge clk) disable iff (rst)
        (acc && !vol_mode && wr_addr == a_code) |=>
        ($stable(nv_code) && dac_code == $past(wr_data)));

    assert_both_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && vol_mode && wr_addr == a_code) |=> (nv_code == $past(wr_data)));

    assert_cross_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && wr_addr == a_row) |=> (dac_code == $past(nv_code)));

    assert_recall_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && !vol_mode && (wr_addr == a_c0 || wr_addr == a_c5)) |=>
        (lut_row == $past(nv_row) && dac_code == $past(nv_code)));
endmodule

bind cfg_shadow_regfile cfg_shadow_chk #(.BASE_ADDR(BASE_ADDR), .ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wp_n     (wp_n),
    .wel      (wel),
    .vol_mode (vol_mode),
    .lut_row  (lut_row),
    .dac_code (dac_code),
    .nv_row   (nv_row),
    .nv_code  (nv_code),
    .ctl_bits ({cur_dir, vol_mode, filt_off, dac_direct, lut_direct, fs_sel[0]})
);

// File: tb/cfg_shadow_regfile_tb.sv
module cfg_shadow_regfile_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       wp_n = 1'b1;
    logic [7:0] status_in = 8'h5A;
    logic       wel, cur_dir, vol_mode, filt_off, dac_direct, lut_direct;
    logic [1:0] fs_sel;
    logic [5:0] lut_row;
    logic [7:0] dac_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cfg_shadow_regfile u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wp_n(wp_n), .status_in(status_in),
        .wel(wel), .cur_dir(cur_dir), .vol_mode(vol_mode), .filt_off(filt_off),
        .dac_direct(dac_direct), .lut_direct(lut_direct), .fs_sel(fs_sel),
        .lut_row(lut_row), .dac_code(dac_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic m_wel;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4 reset state, swept over the whole window
        for (int a = 8'h80; a <= 8'h8F; a++) begin
            logic [7:0] e;
            e = (a == 8'h80) ? 8'h08 : (a == 8'h85) ? 8'h03 : (a == 8'h87) ? status_in : 8'h00;
            rd("R4 reset readback", 8'(a), e);
        end
        chk("R4 wel", wel, 0);
        chk("R4 fs_sel", fs_sel, 3);
        chk("R4 lut_row", lut_row, 0);
        chk("R4 dac_code", dac_code, 0);

        // R11 outside the window
        rd("R11 low addr", 8'h00, 8'h00);
        rd("R11 7Fh", 8'h7F, 8'h00);
        rd("R11 97h", 8'h97, 8'h00);

        // R2 writes blocked while latch clear
        wr(8'h83, 8'h55);
        chk("R2 dac_code", dac_code, 0);
        wr(8'h80, 8'h34);
        rd("R2 80h", 8'h80, 8'h08);
        chk("R2 vol_mode", vol_mode, 0);

        // R1 sweep every data byte against a running model
        m_wel = 1'b0;
        for (int d = 0; d < 256; d++) begin
            wr(8'h86, 8'(d));
            if (d == 8'h80) m_wel = 1'b1;
            else if (d == 8'h00) m_wel = 1'b0;
            chk("R1 latch sweep", wel, m_wel);
        end
        rd("R1 86h set", 8'h86, 8'h80);
        wr(8'h86, 8'h00);
        rd("R1 86h clear", 8'h86, 8'h00);
        wr(8'h86, 8'h80);
        chk("R1 reset again", wel, 1);

        // R3 write protect
        wp_n = 1'b0;
        wr(8'h83, 8'h66);
        chk("R3 dac_code", dac_code, 0);
        wr(8'h85, 8'h00);
        rd("R3 85h", 8'h85, 8'h03);
        wr(8'h86, 8'h00);
        chk("R3 latch clear under protect", wel, 0);
        wr(8'h86, 8'h80);
        chk("R3 latch set under protect", wel, 1);
        wp_n = 1'b1;

        // R11 reserved addresses
        wr(8'h82, 8'hFF);
        wr(8'h8C, 8'hFF);
        wr(8'h8F, 8'hFF);
        rd("R11 82h", 8'h82, 8'h00);
        rd("R11 8Ch", 8'h8C, 8'h00);
        rd("R11 8Fh", 8'h8F, 8'h00);
        wr(8'h03, 8'hAA);
        chk("R11 alias of 83h", dac_code, 0);

        // R5 working copy only, R7 cross recall
        wr(8'h83, 8'hA5);
        chk("R5 dac_code", dac_code, 8'hA5);
        rd("R5 83h retained", 8'h83, 8'h00);
        wr(8'h81, 8'hFF);
        chk("R5 lut_row", lut_row, 6'h3F);
        rd("R9 81h retained", 8'h81, 8'h00);
        chk("R7 code recalled", dac_code, 0);
        wr(8'h83, 8'h5A);
        chk("R7 row recalled", lut_row, 0);

        // R8 recall on 80h/85h writes
        wr(8'h80, 8'h00);
        chk("R8 code recall by 80h", dac_code, 0);
        wr(8'h81, 8'h2A);
        chk("R8 setup row", lut_row, 6'h2A);
        wr(8'h85, 8'h03);
        chk("R8 row recall by 85h", lut_row, 0);

        // R6 both copies
        wr(8'h80, 8'h10);
        chk("R10 vol_mode", vol_mode, 1);
        rd("R10 80h", 8'h80, 8'h18);
        wr(8'h83, 8'hC3);
        chk("R6 dac_code", dac_code, 8'hC3);
        rd("R6 83h", 8'h83, 8'hC3);
        wr(8'h81, 8'hFF);
        rd("R6 81h", 8'h81, 8'h3F);
        chk("R6 lut_row", lut_row, 6'h3F);
        chk("R7 recall of equal copy", dac_code, 8'hC3);

        // R8 again after dropping volatility
        wr(8'h80, 8'h00);
        wr(8'h83, 8'h11);
        chk("R5 dac_code volatile", dac_code, 8'h11);
        rd("R5 83h kept", 8'h83, 8'hC3);
        wr(8'h85, 8'h03);
        chk("R8 recall to retained", dac_code, 8'hC3);

        // R10 field layout
        wr(8'h80, 8'hFF);
        rd("R10 80h all", 8'h80, 8'h3C);
        chk("R10 bits", {cur_dir, vol_mode, filt_off}, 3'b111);
        wr(8'h80, 8'h20);
        rd("R10 80h dir", 8'h80, 8'h28);
        chk("R10 bits dir", {cur_dir, vol_mode, filt_off}, 3'b100);
        wr(8'h80, 8'h04);
        rd("R10 80h filt", 8'h80, 8'h0C);
        wr(8'h85, 8'hFF);
        rd("R10 85h all", 8'h85, 8'h33);
        chk("R10 85h outs", {dac_direct, lut_direct, fs_sel}, 4'b1111);
        wr(8'h85, 8'h21);
        rd("R10 85h mix", 8'h85, 8'h21);
        chk("R10 85h outs mix", {dac_direct, lut_direct, fs_sel}, 4'b1001);

        // R9 status passthrough
        for (int s = 0; s < 256; s += 17) begin
            status_in = 8'(s);
            rd("R9 status", 8'h87, 8'(s));
        end

        finish_run();
    end
endmodule